// File: doc/BRIEF.md
# Periodic Temperature Sample Conditioner with Fault Substitution

This block turns a stream of raw temperature readings from several sensors into values that a fan control policy can trust. Readings arrive one at a time on a valid/data input, each carrying the number of the channel it belongs to. Every channel keeps its own small history: a three-entry median window removes lone outliers, and an exponential moving average with a power-of-two weight smooths what is left. Readings are signed 16-bit values in steps of 1/16 °C.

A free-running divider produces one decision tick every programmed number of clocks. On that tick every channel is judged together. A channel is faulty when it has gone quiet for too long, when a lone jump was thrown away, or when its filtered value moved further than physically possible since the last tick. While a channel is faulty, its output is the last value it reported while healthy, raised by a programmable upward margin that saturates at the largest positive value. A one-cycle alarm is raised when a channel enters the faulty state. The fault is released only after a programmed run of good readings.

Top module: `sensor_conditioner`

## Requirements
- R1: A decision result is presented as a one-cycle `out_valid` pulse, and consecutive pulses are exactly `cfg_tick_period` clocks apart.
- R2: After reset, `out_valid` and `out_alarm` are low, every channel reports stale (`out_stale` bit set) until its first reading arrives, and the value output of such a channel is the bias added to zero.
- R3: Each accepted reading passes through a median of itself and the two previously accepted readings, then an average updated as `avg += (median - avg) >>> cfg_ema_shift`; the first reading of a channel seeds both window and average.
- R4: A channel becomes stale on a tick when no reading has arrived on it during the last `cfg_stale_ticks` tick intervals (the interval ending at this tick included).
- R5: A reading that differs by more than `cfg_spike_delta` from the last accepted reading is held back; if the next reading is within `cfg_spike_delta` of the last accepted reading, the held one is discarded and the spike flag (`out_spike`) is set at the following tick; if the next reading also jumps, it is accepted and no flag is raised.
- R6: On a tick, the slope flag (`out_slope`) is set when the filtered value differs from its value at the previous tick by more than `cfg_max_slope`, provided the channel had data at both ticks.
- R7: While any flag of a channel is set, its value lane is the value it reported at its last fault-free tick plus `cfg_bias`, saturated at 32767; otherwise it is the filtered value.
- R8: A set flag clears on a tick only when at least `cfg_good_samples` accepted readings have arrived since the latest fault event; the reading that exposes a spike is not counted, and a tick that detects stale or slope restarts the count.
- R9: `out_alarm` pulses together with `out_valid` when at least one channel goes from no flag set to some flag set; a channel that stays faulty, even with a changed cause, raises no further alarm.
- R10: A reading tagged with channel `i` affects only channel `i`, whose value lane is `out_value[16*i +: 16]` and whose flags are bit `i` of each flag vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | A reading is presented this cycle |
| smp_chan | input | CHW (2) | Channel number of the reading |
| smp_data | input | DW (16) | Signed reading, 1/16 °C per step |
| cfg_tick_period | input | TW (24) | Clocks per decision tick |
| cfg_stale_ticks | input | SW (8) | Silent tick intervals before stale |
| cfg_spike_delta | input | DW (16) | Largest jump accepted without holding |
| cfg_max_slope | input | DW (16) | Largest per-tick change of the filtered value |
| cfg_bias | input | DW-1 (15) | Upward margin added under fault |
| cfg_good_samples | input | GW (8) | Good readings needed to release a fault |
| cfg_ema_shift | input | SHW (4) | Averaging weight as a right shift |
| out_valid | output | 1 | Decision result present |
| out_value | output | N_CH*DW (64) | Conditioned value per channel |
| out_stale | output | N_CH (4) | Stale flag per channel |
| out_spike | output | N_CH (4) | Spike flag per channel |
| out_slope | output | N_CH (4) | Impossible-slope flag per channel |
| out_alarm | output | 1 | Fault-entry alarm pulse |

## Verification
A reading updates the channel's filter on the clock edge where it is presented, while every decision result appears one clock after the tick edge, on the single cycle `out_valid` is high. The bench therefore presents all readings of an interval right after a result has been seen, far from the next tick, queues the values it expects for that tick, and compares lanes, flags and alarm only in the cycle `out_valid` is high. The distance between two result pulses is measured in clocks and compared with the programmed period.

// File: rtl/sens_cond_pkg.sv
package sens_cond_pkg;

   // Per-channel fault state, most significant field first.
   typedef struct packed {
      logic stale;
      logic spike;
      logic slope;
   } fault_t;

   localparam fault_t FAULT_NONE  = 3'b000;
   localparam fault_t FAULT_BOOT  = 3'b100;

endpackage

// File: rtl/sens_cond_tick.sv
module sens_cond_tick #(
   parameter int TW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] cfg_period,
   output logic          tick
);

   logic [TW-1:0] cnt_q;

   // A period of 0 or 1 ticks on every clock.
   assign tick = ({1'b0, cnt_q} + {{TW{1'b0}}, 1'b1}) >= {1'b0, cfg_period};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cfg_period > 1) |=> (!tick || cfg_period <= 1)); // R1

endmodule

// File: rtl/sens_cond_chan.sv
module sens_cond_chan
   import sens_cond_pkg::*;
#(
   parameter int DW        = 16,
   parameter int SW        = 8,
   parameter int GW        = 8,
   parameter int SHW       = 4,
   parameter bit MEDIAN_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_we,
   input  logic signed [DW-1:0] smp_data,
   input  logic                 eval,
   input  logic [SW-1:0]        cfg_stale_ticks,
   input  logic [DW-1:0]        cfg_spike_delta,
   input  logic [DW-1:0]        cfg_max_slope,
   input  logic [DW-2:0]        cfg_bias,
   input  logic [GW-1:0]        cfg_good_samples,
   input  logic [SHW-1:0]       cfg_ema_shift,
   output logic signed [DW-1:0] value,
   output fault_t               flags,
   output logic                 entry
);

   localparam logic signed [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};

   function automatic logic [DW:0] mag(input logic signed [DW-1:0] a,
                                       input logic signed [DW-1:0] b);
      logic signed [DW:0] d;
      d = (DW+1)'(a) - (DW+1)'(b);
      return d[DW] ? -d : d;
   endfunction

   function automatic logic signed [DW-1:0] med3(input logic signed [DW-1:0] a,
                                                 input logic signed [DW-1:0] b,
                                                 input logic signed [DW-1:0] c);
      logic signed [DW-1:0] lo, hi, m;
      lo = (a < b) ? a : b;
      hi = (a < b) ? b : a;
      m  = (c < hi) ? c : hi;
      return (m > lo) ? m : lo;
   endfunction

   logic                 have_q, pend_q, seen_q, spk_q, prev_ok_q;
   logic signed [DW-1:0] prev_q, ema_q, lkg_q, last_q, val_q, med;
   logic [GW-1:0]        good_q;
   logic [SW-1:0]        idle_q, idle_n;
   fault_t               flt_q, flt_n;

   // Reading classification
   logic jump, accept, spike_evt, hold_new, count_good;
   assign jump       = mag(smp_data, prev_q) > {1'b0, cfg_spike_delta};
   assign accept     = smp_we && (!have_q || !jump || pend_q);
   assign spike_evt  = smp_we && have_q && pend_q && !jump;
   assign hold_new   = smp_we && have_q && !pend_q && jump;
   assign count_good = accept && !spike_evt;

   // Filter front end: median window or pass-through
   generate
      if (MEDIAN_EN) begin : g_med
         logic signed [DW-1:0] win0_q, win1_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win0_q <= '0;
               win1_q <= '0;
            end else if (accept) begin
               win0_q <= smp_data;
               win1_q <= have_q ? win0_q : smp_data;
            end
         end
         assign med = med3(smp_data, win0_q, win1_q);
      end else begin : g_pass
         assign med = smp_data;
      end
   endgenerate

   logic signed [DW:0] e_diff, e_step, e_sum;
   assign e_diff = (DW+1)'(med) - (DW+1)'(ema_q);
   assign e_step = e_diff >>> cfg_ema_shift;
   assign e_sum  = (DW+1)'(ema_q) + e_step;

   // Tick evaluation
   logic               stale_now, slope_now, good_ok, fault_any;
   logic signed [DW:0] b_sum;
   logic signed [DW-1:0] biased;

   assign idle_n    = (seen_q || smp_we) ? '0 : ((&idle_q) ? idle_q : idle_q + 1'b1);
   assign stale_now = !have_q || (idle_n >= cfg_stale_ticks);
   assign slope_now = have_q && prev_ok_q && (mag(ema_q, last_q) > {1'b0, cfg_max_slope});
   assign good_ok   = good_q >= cfg_good_samples;

   assign flt_n.stale = stale_now             || (flt_q.stale && !good_ok);
   assign flt_n.spike = spk_q || spike_evt    || (flt_q.spike && !good_ok);
   assign flt_n.slope = slope_now             || (flt_q.slope && !good_ok);
   assign fault_any   = |flt_n;

   assign b_sum  = (DW+1)'(lkg_q) + (DW+1)'(cfg_bias);
   assign biased = (b_sum[DW:DW-1] == 2'b01) ? POS_MAX : b_sum[DW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_q    <= 1'b0;
         pend_q    <= 1'b0;
         seen_q    <= 1'b0;
         spk_q     <= 1'b0;
         prev_ok_q <= 1'b0;
         prev_q    <= '0;
         ema_q     <= '0;
         lkg_q     <= '0;
         last_q    <= '0;
         val_q     <= '0;
         good_q    <= '0;
         idle_q    <= '0;
         flt_q     <= FAULT_BOOT;
         entry     <= 1'b0;
      end else begin
         if (accept) begin
            prev_q <= smp_data;
            ema_q  <= have_q ? e_sum[DW-1:0] : smp_data;
            have_q <= 1'b1;
         end
         if (smp_we) pend_q <= hold_new;
         seen_q <= !eval && (seen_q || smp_we);
         spk_q  <= !eval && (spk_q || spike_evt);

         if (eval && (stale_now || slope_now)) good_q <= '0;
         else if (spike_evt)                  good_q <= '0;
         else if (count_good && !(&good_q))   good_q <= good_q + 1'b1;

         entry <= eval && fault_any && !(|flt_q);
         if (eval) begin
            flt_q     <= flt_n;
            val_q     <= fault_any ? biased : ema_q;
            if (!fault_any) lkg_q <= ema_q;
            last_q    <= ema_q;
            prev_ok_q <= have_q;
            idle_q    <= idle_n;
         end
      end
   end

   assign value = val_q;
   assign flags = flt_q;

   AST_STALE_UNTIL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      !have_q |-> flt_q.stale); // R2
   AST_FAULT_NOT_BELOW_LKG: assert property (@(posedge clk) disable iff (!rst_n)
      (|flt_q) |-> (val_q >= lkg_q)); // R7
   AST_SPIKE_RESTARTS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      spike_evt |=> (good_q == '0)); // R8
   AST_HELD_NOT_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
      hold_new |=> $stable(ema_q)); // R5

endmodule

// File: rtl/sensor_conditioner.sv
module sensor_conditioner
   import sens_cond_pkg::*;
#(
   parameter int N_CH      = 4,
   parameter int DW        = 16,
   parameter int TW        = 24,
   parameter int SW        = 8,
   parameter int GW        = 8,
   parameter bit MEDIAN_EN = 1'b1,
   localparam int CHW      = (N_CH > 1) ? $clog2(N_CH) : 1,
   localparam int SHW      = $clog2(DW)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_valid,
   input  logic [CHW-1:0]     smp_chan,
   input  logic [DW-1:0]      smp_data,
   input  logic [TW-1:0]      cfg_tick_period,
   input  logic [SW-1:0]      cfg_stale_ticks,
   input  logic [DW-1:0]      cfg_spike_delta,
   input  logic [DW-1:0]      cfg_max_slope,
   input  logic [DW-2:0]      cfg_bias,
   input  logic [GW-1:0]      cfg_good_samples,
   input  logic [SHW-1:0]     cfg_ema_shift,
   output logic               out_valid,
   output logic [N_CH*DW-1:0] out_value,
   output logic [N_CH-1:0]    out_stale,
   output logic [N_CH-1:0]    out_spike,
   output logic [N_CH-1:0]    out_slope,
   output logic               out_alarm
);

   generate
      if (N_CH < 1) begin : g_bad_nch
         $error("N_CH must be at least 1");
      end
      if (DW < 8) begin : g_bad_dw
         $error("DW must be at least 8");
      end
      if (TW < 2 || SW < 1 || GW < 1) begin : g_bad_cnt
         $error("TW, SW and GW are too narrow");
      end
   endgenerate

   logic            tick;
   logic [N_CH-1:0] entry;

   sens_cond_tick #(.TW(TW)) u_tick (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_period (cfg_tick_period),
      .tick       (tick)
   );

   generate
      for (genvar i = 0; i < N_CH; i++) begin : g_ch
         fault_t f;
         sens_cond_chan #(
            .DW(DW), .SW(SW), .GW(GW), .SHW(SHW), .MEDIAN_EN(MEDIAN_EN)
         ) u_ch (
            .clk              (clk),
            .rst_n            (rst_n),
            .smp_we           (smp_valid && (smp_chan == CHW'(i))),
            .smp_data         (smp_data),
            .eval             (tick),
            .cfg_stale_ticks  (cfg_stale_ticks),
            .cfg_spike_delta  (cfg_spike_delta),
            .cfg_max_slope    (cfg_max_slope),
            .cfg_bias         (cfg_bias),
            .cfg_good_samples (cfg_good_samples),
            .cfg_ema_shift    (cfg_ema_shift),
            .value            (out_value[i*DW +: DW]),
            .flags            (f),
            .entry            (entry[i])
         );
         assign out_stale[i] = f.stale;
         assign out_spike[i] = f.spike;
         assign out_slope[i] = f.slope;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= tick;
   end

   assign out_alarm = |entry;

   AST_ALARM_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      out_alarm |-> out_valid); // R9
   AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cfg_tick_period > 1 && $past(cfg_tick_period) > 1) |=> !out_valid); // R1

endmodule

// File: tb/tb_sensor_conditioner.sv
`timescale 1ns/1ps
module tb_sensor_conditioner;

   localparam int PERIOD = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [1:0]  smp_chan = '0;
   logic [15:0] smp_data = '0;
   logic [23:0] cfg_tick_period = 24'(PERIOD);
   logic [7:0]  cfg_stale_ticks = 8'd2;
   logic [15:0] cfg_spike_delta = 16'd80;
   logic [15:0] cfg_max_slope = 16'd160;
   logic [14:0] cfg_bias = 15'd32;
   logic [7:0]  cfg_good_samples = 8'd2;
   logic [3:0]  cfg_ema_shift = 4'd0;
   logic        out_valid, out_alarm;
   logic [63:0] out_value;
   logic [3:0]  out_stale, out_spike, out_slope;

   sensor_conditioner dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
      .smp_data(smp_data), .cfg_tick_period(cfg_tick_period),
      .cfg_stale_ticks(cfg_stale_ticks), .cfg_spike_delta(cfg_spike_delta),
      .cfg_max_slope(cfg_max_slope), .cfg_bias(cfg_bias),
      .cfg_good_samples(cfg_good_samples), .cfg_ema_shift(cfg_ema_shift),
      .out_valid(out_valid), .out_value(out_value), .out_stale(out_stale),
      .out_spike(out_spike), .out_slope(out_slope), .out_alarm(out_alarm)
   );

   always #4 clk = ~clk;

   typedef struct packed {
      logic [63:0] v;
      logic [3:0]  st;
      logic [3:0]  sp;
      logic [3:0]  sl;
      logic        al;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   int    cyc = 0;
   int    last_valid_cyc = -1;

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic exp_t mk(input int v0, input int v1, input int v2, input int v3,
                               input logic [3:0] st, input logic [3:0] sp,
                               input logic [3:0] sl, input logic al);
      exp_t e;
      e.v  = {16'(v3), 16'(v2), 16'(v1), 16'(v0)};
      e.st = st; e.sp = sp; e.sl = sl; e.al = al;
      return e;
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: pops one expected item per result pulse.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (last_valid_cyc >= 0)
            check("R1", "result spacing", 64'(cyc - last_valid_cyc), 64'(PERIOD));
         last_valid_cyc = cyc;
         if (exp_q.size() == 0) begin
            check("R1", "unexpected result", 64'd1, 64'd0);
         end else begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            for (int c = 0; c < 4; c++)
               check(t, $sformatf("lane %0d value", c),
                     64'(out_value[c*16 +: 16]), 64'(e.v[c*16 +: 16]));
            check(t, "stale flags", 64'(out_stale), 64'(e.st));
            check(t, "spike flags", 64'(out_spike), 64'(e.sp));
            check(t, "slope flags", 64'(out_slope), 64'(e.sl));
            check(t, "alarm", 64'(out_alarm), 64'(e.al));
         end
      end
   end

   task automatic smp(input int ch, input int val);
      smp_valid = 1'b1;
      smp_chan  = 2'(ch);
      smp_data  = 16'(val);
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic others();
      smp(1, 400); smp(2, 400); smp(3, 400);
   endtask

   task automatic expect_tick(input exp_t e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      do @(negedge clk); while (!out_valid);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check("R2", "valid in reset window", 64'(out_valid), 64'd0);
      check("R2", "alarm in reset window", 64'(out_alarm), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2", "valid after reset", 64'(out_valid), 64'd0);

      expect_tick(mk(32, 32, 32, 32, 4'hF, 4'h0, 4'h0, 1'b0), "R2");
      others(); smp(0, 320);
      expect_tick(mk(32, 32, 32, 32, 4'hF, 4'h0, 4'h0, 1'b0), "R8");
      others(); smp(0, 336);
      expect_tick(mk(320, 400, 400, 400, 4'h0, 4'h0, 4'h0, 1'b0), "R3 R10");
      others(); smp(0, 352); smp(0, 352);
      expect_tick(mk(352, 400, 400, 400, 4'h0, 4'h0, 4'h0, 1'b0), "R3");
      others(); smp(0, 900); smp(0, 360); smp(0, 368);
      expect_tick(mk(384, 400, 400, 400, 4'h0, 4'h1, 4'h0, 1'b1), "R5 R7 R9");
      others(); smp(0, 368);
      expect_tick(mk(368, 400, 400, 400, 4'h0, 4'h0, 4'h0, 1'b0), "R5 R8");
      others(); smp(0, 600); smp(0, 610); smp(0, 620);
      expect_tick(mk(400, 400, 400, 400, 4'h0, 4'h0, 4'h1, 1'b1), "R6 R7");
      others(); smp(0, 620); smp(0, 620);
      expect_tick(mk(620, 400, 400, 400, 4'h0, 4'h0, 4'h0, 1'b0), "R6 R8");
      others();
      expect_tick(mk(620, 400, 400, 400, 4'h0, 4'h0, 4'h0, 1'b0), "R4");
      others();
      expect_tick(mk(652, 400, 400, 400, 4'h1, 4'h0, 4'h0, 1'b1), "R4 R9");
      others(); smp(0, 32760); smp(0, 32760); smp(0, 32760);
      expect_tick(mk(652, 400, 400, 400, 4'h0, 4'h0, 4'h1, 1'b0), "R9");
      others(); smp(0, 32760); smp(0, 32760);
      expect_tick(mk(32760, 400, 400, 400, 4'h0, 4'h0, 4'h0, 1'b0), "R6");
      others();
      expect_tick(mk(32760, 400, 400, 400, 4'h0, 4'h0, 4'h0, 1'b0), "R4");
      others();
      expect_tick(mk(32767, 400, 400, 400, 4'h1, 4'h0, 4'h0, 1'b1), "R7");
      cfg_ema_shift = 4'd2;
      smp(1, 464); smp(1, 464); smp(1, 464); smp(2, 400); smp(3, 400);
      expect_tick(mk(32767, 428, 400, 400, 4'h1, 4'h0, 4'h0, 1'b0), "R3 R10");

      repeat (3) @(negedge clk);
      check("R1", "results left unmatched", 64'(exp_q.size()), 64'd0);
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      end
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL R1 watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      end
      $finish;
   end

endmodule